// File: doc/BRIEF.md
# Three-Level Servo PWM Generator

This block turns a signed 8-bit servo drive value into a pulse-width output that runs on a fixed carrier of 192 system clocks. At a 16.9344 MHz system clock this gives an 88.2 kHz carrier. The default output has three levels: drive high, drive low, and a released mid level. In the released state the driver is disabled and an external network holds the line at mid-reference. The sign of the sample picks the direction and its magnitude sets the pulse length. Every pulse starts at the beginning of the period.

An active-low mode input selects a second output style. In that style one push-pull bit is high for a share of the period proportional to the offset-binary value, and the three-level driver is released. Samples may arrive at any time, marked by a valid strobe. They are held and take effect only at the next period boundary, so a running pulse is never cut short. Several instances can run from the same clock and reset and stay in step.

The core is a registered level state machine with five states. `LV_MID` is released. `LV_HIGH` drives high and `LV_LOW` drives low. `PP_HIGH` and `PP_LOW` are the two-state levels. On each clock edge the next state is chosen from the next carrier position, the sample that will be active, and the mode input:
- In two-state mode the machine goes to `PP_HIGH` while the position is below the threshold, and to `PP_LOW` otherwise.
- In three-level mode it goes to `LV_HIGH` or `LV_LOW`, by sign, while the position is below the magnitude, and to `LV_MID` otherwise.
- Reset forces `LV_MID`.

Any state can move to any other state on the next edge.

Top module: `servo_pwm3`

## Requirements
- R1: While rst_n is low, drv_hi_o, drv_lo_o, drv_oe_o and pwm2_o are all 0.
- R2: The carrier position is 0 during reset. It advances by one on each clock and wraps from 191 to 0, so every period is 192 clocks.
- R3: In three-level mode with an active value v > 0, the outputs are drv_oe_o=1, drv_hi_o=1, drv_lo_o=0 at positions 0 to v-1. They are all 0 (mid level) for the rest of the period.
- R4: In three-level mode with an active value v < 0, the outputs are drv_oe_o=1, drv_lo_o=1, drv_hi_o=0 at positions 0 to |v|-1. They are at the mid level for the rest of the period.
- R5: An active value of 0 gives the mid level for the whole period in three-level mode.
- R6: A sample of -128 (0x80) is stored as -127, so it drives low for 127 clocks.
- R7: When mode2_n_i is 0, pwm2_o is 1 at positions below floor((v+128)*192/256) and 0 at the other positions. drv_oe_o, drv_hi_o and drv_lo_o are 0 in this mode.
- R8: When mode2_n_i is 1, pwm2_o is 0.
- R9: A sample given with samp_vld_i is held. It becomes the active value at the first position 0 after it. If several samples arrive before the boundary, the last one wins, and this includes a sample given at position 191.
- R10: The outputs in a cycle follow the mode sampled at the clock edge that opens the cycle. The mode may change in the middle of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_i | input | 8 | Signed two's-complement drive value |
| samp_vld_i | input | 1 | Strobe marking samp_i as a new sample |
| mode2_n_i | input | 1 | 0 selects the two-state output, 1 selects the three-level output |
| drv_hi_o | output | 1 | Drive line to the high reference |
| drv_lo_o | output | 1 | Drive line low |
| drv_oe_o | output | 1 | Driver enable; 0 means released to mid level |
| pwm2_o | output | 1 | Two-state push-pull PWM bit |

## Verification
A sample given in the cycle at position p first appears in the cycle at position 0 of the next period. The mode value present at an edge controls the cycle that the edge opens, so a mode change is visible one clock after it is driven. The bench drives inputs just after the falling edge. Its model updates on the rising edge using those inputs and computes the expected levels for the cycle just opened. The model's values are compared with the outputs at the next falling edge on every clock, including a sample placed exactly at position 191 and a mode flip in mid-period.

// File: rtl/servo_pwm_pkg.sv
package servo_pwm_pkg;

    // Registered output level of the generator
    typedef enum logic [2:0] {
        LV_MID  = 3'd0,
        LV_HIGH = 3'd1,
        LV_LOW  = 3'd2,
        PP_HIGH = 3'd3,
        PP_LOW  = 3'd4
    } lvl_state_e;

endpackage

// File: rtl/servo_pwm_carrier.sv
module servo_pwm_carrier #(
    parameter int PERIOD = 192,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    always_comb begin
        last_o = (cnt_q == LAST);
        cnt_d  = last_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/servo_pwm_sample_hold.sv
module servo_pwm_sample_hold #(
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [DATA_W-1:0] samp_i,
    input  logic                     samp_vld_i,
    input  logic                     wrap_i,
    output logic signed [DATA_W-1:0] act_q,
    output logic signed [DATA_W-1:0] act_d
);
    localparam logic signed [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic signed [DATA_W-1:0] SAT_NEG  = MOST_NEG + 1'b1;

    logic signed [DATA_W-1:0] pend_q, pend_d, sat_v;

    always_comb begin
        sat_v  = (samp_i == MOST_NEG) ? SAT_NEG : samp_i;
        pend_d = samp_vld_i ? sat_v : pend_q;
        act_d  = wrap_i ? pend_d : act_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            pend_q <= pend_d;
            act_q  <= act_d;
        end
    end
endmodule

// File: rtl/servo_pwm_level_fsm.sv
module servo_pwm_level_fsm
    import servo_pwm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PERIOD = 192,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CNT_W-1:0]         cnt_d,
    input  logic signed [DATA_W-1:0] act_d,
    input  logic                     mode2_n_i,
    output logic                     drv_hi_o,
    output logic                     drv_lo_o,
    output logic                     drv_oe_o,
    output logic                     pwm2_o
);
    localparam int PROD_W = DATA_W + $clog2(PERIOD + 1);

    lvl_state_e state_q, state_d;
    logic [PROD_W-1:0] off_w, thr_w, cnt_w, mag_w;
    logic signed [DATA_W-1:0] mag_v;
    logic act_neg;

    // next-state selection from the next position and next active value
    always_comb begin
        act_neg = act_d[DATA_W-1];
        off_w   = PROD_W'({~act_d[DATA_W-1], act_d[DATA_W-2:0]});
        thr_w   = (off_w * PROD_W'(PERIOD)) >> DATA_W;
        mag_v   = act_neg ? -act_d : act_d;
        mag_w   = PROD_W'($unsigned(mag_v));
        cnt_w   = PROD_W'(cnt_d);
        if (!mode2_n_i)
            state_d = (cnt_w < thr_w) ? PP_HIGH : PP_LOW;
        else if (cnt_w < mag_w)
            state_d = act_neg ? LV_LOW : LV_HIGH;
        else
            state_d = LV_MID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LV_MID;
        else        state_q <= state_d;
    end

    always_comb begin
        drv_hi_o = 1'b0;
        drv_lo_o = 1'b0;
        drv_oe_o = 1'b0;
        pwm2_o   = 1'b0;
        unique case (state_q)
            LV_MID:  ;
            LV_HIGH: begin drv_oe_o = 1'b1; drv_hi_o = 1'b1; end
            LV_LOW:  begin drv_oe_o = 1'b1; drv_lo_o = 1'b1; end
            PP_HIGH: pwm2_o = 1'b1;
            PP_LOW:  ;
            default: ;
        endcase
    end
endmodule

// File: rtl/servo_pwm3.sv
module servo_pwm3 #(
    parameter int DATA_W = 8,
    parameter int PERIOD = 192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] samp_i,
    input  logic              samp_vld_i,
    input  logic              mode2_n_i,
    output logic              drv_hi_o,
    output logic              drv_lo_o,
    output logic              drv_oe_o,
    output logic              pwm2_o
);
    localparam int CNT_W = $clog2(PERIOD);

    logic [CNT_W-1:0]         phase_q, phase_d;
    logic                     wrap;
    logic signed [DATA_W-1:0] act_q, act_d;

    servo_pwm_carrier #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_carrier (
        .clk(clk), .rst_n(rst_n),
        .cnt_q(phase_q), .cnt_d(phase_d), .last_o(wrap)
    );

    servo_pwm_sample_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n),
        .samp_i($signed(samp_i)), .samp_vld_i(samp_vld_i), .wrap_i(wrap),
        .act_q(act_q), .act_d(act_d)
    );

    servo_pwm_level_fsm #(.DATA_W(DATA_W), .PERIOD(PERIOD), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cnt_d(phase_d), .act_d(act_d), .mode2_n_i(mode2_n_i),
        .drv_hi_o(drv_hi_o), .drv_lo_o(drv_lo_o),
        .drv_oe_o(drv_oe_o), .pwm2_o(pwm2_o)
    );
endmodule

// File: rtl/servo_pwm3_chk.sv
module servo_pwm3_chk #(
    parameter int DATA_W = 8,
    parameter int PERIOD = 192,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     mode2_n_i,
    input logic                     drv_hi_o,
    input logic                     drv_lo_o,
    input logic                     drv_oe_o,
    input logic                     pwm2_o,
    input logic [CNT_W-1:0]         phase,
    input logic signed [DATA_W-1:0] act
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    // R1
    always @(negedge clk)
        if (!rst_n)
            a_r1_reset_quiet: assert (!drv_oe_o && !drv_hi_o && !drv_lo_o && !pwm2_o);

    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == LAST) |=> (phase == '0));

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != LAST) |=> (phase == CNT_W'($past(phase) + 1'b1)));

    a_r3_high_within_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        drv_hi_o |-> (act > 0) && (int'(phase) < int'(act)));

    a_r4_low_within_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        drv_lo_o |-> (act < 0) && (int'(phase) < -int'(act)));

    a_r6_no_most_negative: assert property (@(posedge clk) disable iff (!rst_n)
        int'(act) != -(2 ** (DATA_W - 1)));

    a_r7_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        pwm2_o |-> (!drv_oe_o && !drv_hi_o && !drv_lo_o));

    a_r9_value_held_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != '0) |-> $stable(act));

    a_r9_pulse_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_oe_o) |-> (phase == '0) || !$past(mode2_n_i, 2));
endmodule

bind servo_pwm3 servo_pwm3_chk #(.DATA_W(DATA_W), .PERIOD(PERIOD), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode2_n_i(mode2_n_i),
    .drv_hi_o(drv_hi_o), .drv_lo_o(drv_lo_o), .drv_oe_o(drv_oe_o), .pwm2_o(pwm2_o),
    .phase(phase_q), .act(act_q)
);

// File: tb/sim_servo_pwm3.sv
`timescale 1ns/1ps
module sim_servo_pwm3;
    localparam int P = 192;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] samp = 8'h00;
    logic       vld = 1'b0;
    logic       mode2_n = 1'b1;
    logic       hi, lo, oe, pw;

    int compared = 0, mismatched = 0, cycles = 0;
    int m_cnt = 0, m_act = 0, m_pend = 0;
    bit e_hi = 0, e_lo = 0, e_oe = 0, e_pw = 0;
    bit m_mode = 1;
    string seg = "R1 reset";

    always #2.5 clk = ~clk;

    servo_pwm3 u0 (
        .clk(clk), .rst_n(rst_n), .samp_i(samp), .samp_vld_i(vld), .mode2_n_i(mode2_n),
        .drv_hi_o(hi), .drv_lo_o(lo), .drv_oe_o(oe), .pwm2_o(pw)
    );

    // behavioural reference: position, held and active values as integers
    always @(posedge clk) begin
        int s;
        if (!rst_n) begin
            m_cnt = 0; m_act = 0; m_pend = 0;
            e_hi = 0; e_lo = 0; e_oe = 0; e_pw = 0;
        end else begin
            s = $signed(samp);
            if (s == -128) s = -127;
            if (m_cnt == P - 1) begin
                m_cnt = 0;
                m_act = vld ? s : m_pend;
            end else m_cnt = m_cnt + 1;
            if (vld) m_pend = s;
            m_mode = mode2_n;
            e_hi = 0; e_lo = 0; e_oe = 0; e_pw = 0;
            if (!m_mode) e_pw = (m_cnt < ((m_act + 128) * P) / 256);
            else if (m_act > 0 && m_cnt < m_act) begin e_hi = 1; e_oe = 1; end
            else if (m_act < 0 && m_cnt < -m_act) begin e_lo = 1; e_oe = 1; end
        end
    end

    always @(negedge clk) begin
        string tag;
        cycles++;
        compared++;
        if ({hi, lo, oe, pw} !== {e_hi, e_lo, e_oe, e_pw}) begin
            if (!rst_n) tag = "R1";
            else if (!m_mode) tag = "R7";
            else if (pw !== 1'b0) tag = "R8";
            else if (m_act == -127) tag = "R6";
            else if (m_act > 0) tag = "R3";
            else if (m_act < 0) tag = "R4";
            else tag = "R5";
            mismatched++;
            $display("FAIL %s [%s] pos=%0d act=%0d hi/lo/oe/pwm actual=%b%b%b%b expected=%b%b%b%b",
                     tag, seg, m_cnt, m_act, hi, lo, oe, pw, e_hi, e_lo, e_oe, e_pw);
        end
        if (cycles > 100000) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic give(input int v);
        samp = 8'(v); vld = 1'b1;
        step(1);
        vld = 1'b0;
    endtask

    task automatic to_pos(input int p);
        while (m_cnt != p) step(1);
    endtask

    initial begin
        step(6);
        rst_n = 1'b1;
        seg = "R2 idle carrier"; step(2 * P);
        seg = "R3 R9 positive";  give(50); step(2 * P);
        seg = "R3 full scale";   give(127); step(2 * P);
        seg = "R4 negative";     give(-30); step(2 * P);
        seg = "R5 zero";         give(0); step(2 * P);
        seg = "R6 saturation";   give(-128); step(2 * P);
        seg = "R9 last wins";    to_pos(20); give(10); give(90); step(P + 10);
        seg = "R9 boundary";     to_pos(P - 1); give(-64); step(2 * P);
        seg = "R9 late";         to_pos(P - 2); give(33); step(2 * P);
        seg = "R7 two-state";    mode2_n = 1'b0;
        give(-128); step(2 * P);
        give(127); step(2 * P);
        give(-1); step(2 * P);
        give(0); step(2 * P);
        seg = "R10 mid switch";  give(100); to_pos(40); mode2_n = 1'b1;
        step(30); mode2_n = 1'b0; step(50); mode2_n = 1'b1; step(2 * P);
        seg = "R1 reset again";  rst_n = 1'b0; step(5); rst_n = 1'b1; step(P);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule